// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one timer channel of a programmable interval counter. A host-side block writes a starting count with a load strobe and selects one of six operating modes. From then on the channel counts the ticks marked by a clock-enable input, and drives an output pin whose waveform depends on the mode. Depending on the mode, the output can be a one-time terminal flag, a retriggerable one-shot, a periodic rate pulse, a square wave, or a single-tick strobe. The channel also presents a readable count value for the host-side block to latch. Counting is always binary, and a starting count of zero stands for 65536 (one more than the largest counter value).

Inside, the channel measures elapsed ticks since the last load or gate restart. It derives both the output pin and the readable count from that measurement. The gate input either restarts the period on a rising edge or suspends counting while it is low, depending on the mode. Mode codes 6 and 7 behave as codes 2 and 3.

Top module: `ic_channel`

## Requirements
- R1: The reset is synchronous and active low. After reset, the starting count is zero, meaning 65536, and no ticks have elapsed. With mode 3 selected, the readable count is therefore 0 and the output is high.
- R2: When load is high on a clock edge, the starting count is captured from load_val_i and the elapsed-tick measurement returns to zero, whether or not a tick is present. In the following cycle, the readable count equals the loaded value in every mode.
- R3: A loaded value of 0 behaves as a count of 65536 in every output and count formula.
- R4: In mode 0, the output is low after a load and goes high once the elapsed ticks reach the count. It stays high until the next load.
- R5: In mode 1, the output is low while the elapsed ticks are below the count and high afterwards. A rising gate edge seen on a tick restarts the one-shot.
- R6: In mode 2, the output is high except for a low level while the elapsed ticks are a nonzero multiple of the count. For any count above 1, this low level lasts one tick.
- R7: In mode 3, the output is high while (elapsed mod count) is below (count+1)/2, and low otherwise.
- R8: In modes 4 and 5, the output is high only while the elapsed ticks equal the count. Mode 5 restarts on a rising gate edge.
- R9: The readable count is (count − elapsed) mod 65536 in modes 0, 1, 4 and 5. In mode 2 it is count − (elapsed mod count). In mode 3 it is count − ((2·elapsed) mod count). Each result is taken mod 65536.
- R10: In modes 0 and 4, a tick with gate low does not advance the elapsed measurement.
- R11: State changes only on edges where the tick enable or load is high. A rising gate edge is detected only between successive ticks, and in modes 1, 2, 3 and 5 it sets the elapsed measurement to zero on that tick.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Counting tick enable |
| gate_i | input | 1 | Gate level |
| load_i | input | 1 | Starting-count write strobe |
| load_val_i | input | CNT_W | Starting count (0 means 2^CNT_W) |
| mode_i | input | 3 | Operating mode code |
| cnt_o | output | CNT_W | Readable current count |
| out_o | output | 1 | Mode-dependent output pin |

## Verification
The bench builds the channel with the default counter width of 16. This puts the zero-means-65536 boundary in reach: one uninterrupted run in mode 0 passes the full 65536-tick terminal point and the wrap of the readable count. The random segments use small starting counts from 1 to 24, so the channel runs through many rate and square-wave periods, odd-count square waves, and the count-of-one corner. These segments also mix sparse ticks with gate toggles and all eight mode codes.

// File: rtl/ic_pkg.sv
// Package: shared mode encoding and per-mode gate rules for the counter channel.
// Assumes mode codes 6 and 7 fold onto 2 and 3.
package ic_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } ic_mode_e;

    // Map the raw 3-bit code onto one of the six modes.
    function automatic ic_mode_e fold_mode(input logic [2:0] code);
        if (code[2] && code[1])
            return ic_mode_e'({1'b0, code[1:0]});
        return ic_mode_e'(code);
    endfunction

    // Modes where a rising gate edge restarts the period.
    function automatic logic gate_restarts(input ic_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
    endfunction

    // Modes where a low gate holds the count.
    function automatic logic gate_suspends(input ic_mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

endpackage

// File: rtl/ic_elapsed.sv
// Elapsed-tick tracker. Keeps three views of the ticks since the last load or
// gate restart: a wrapping CNT_W-bit total, a total saturating just above the
// span, and the phase within the period (total mod span).
// Assumes span is in 1..2^CNT_W and only changes on a load.
module ic_elapsed
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic              load,
    input  ic_mode_e          mode,
    input  logic [CNT_W:0]    span,
    output logic [CNT_W-1:0]  wrap_d,
    output logic [CNT_W:0]    run_d,
    output logic [CNT_W:0]    phase
);

    localparam int SPAN_W = CNT_W + 1;

    logic gate_q;
    logic rise;
    logic hold;

    assign rise = tick && gate && !gate_q;
    assign hold = gate_suspends(mode) && !gate;

    // Gate level seen at the previous tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (tick)
            gate_q <= gate;
    end

    // Advance, restart or clear the elapsed-tick views.
    always_ff @(posedge clk) begin
        if (!rst_n || load || (rise && gate_restarts(mode))) begin
            wrap_d <= '0;
            run_d  <= '0;
            phase  <= '0;
        end else if (tick && !hold) begin
            wrap_d <= wrap_d + CNT_W'(1);
            if (run_d <= span)
                run_d <= run_d + SPAN_W'(1);
            phase  <= (phase == span - SPAN_W'(1)) ? '0 : phase + SPAN_W'(1);
        end
    end

endmodule

// File: rtl/ic_wave.sv
// Output waveform decoder. Derives the pin level from the elapsed views and
// the span. Purely combinational. Assumes run_d saturates at span+1.
module ic_wave
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ic_mode_e          mode,
    input  logic [CNT_W:0]    span,
    input  logic [CNT_W:0]    run_d,
    input  logic [CNT_W:0]    phase,
    output logic              pin
);

    localparam int EXT_W = CNT_W + 2;

    logic [EXT_W-1:0] half;
    logic             started;
    logic             reached;
    logic             at_span;

    assign half    = ({1'b0, span} + EXT_W'(1)) >> 1;
    assign started = (run_d != '0);
    assign reached = (run_d >= span);
    assign at_span = (run_d == span);

    // Select the pin level for the active mode.
    always_comb begin
        unique case (mode)
            M_TERM, M_ONESHOT:     pin = reached;
            M_RATE:                pin = !((phase == '0) && started);
            M_SQUARE:              pin = ({1'b0, phase} < half);
            M_SWSTROBE, M_HWSTROBE: pin = at_span;
            default:               pin = 1'b1;
        endcase
    end

endmodule

// File: rtl/ic_readout.sv
// Readable count generator. Converts the elapsed views into the count the host
// side sees. Purely combinational. Assumes phase < span.
module ic_readout
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ic_mode_e          mode,
    input  logic [CNT_W:0]    span,
    input  logic [CNT_W-1:0]  wrap_d,
    input  logic [CNT_W:0]    phase,
    output logic [CNT_W-1:0]  cnt
);

    localparam int SPAN_W = CNT_W + 1;
    localparam int EXT_W  = CNT_W + 2;

    logic [EXT_W-1:0] dbl;
    logic [EXT_W-1:0] fold;

    assign dbl  = {phase, 1'b0};
    assign fold = (dbl >= {1'b0, span}) ? dbl - {1'b0, span} : dbl;

    // Pick the count formula for the active mode.
    always_comb begin
        unique case (mode)
            M_RATE:   cnt = CNT_W'(span - phase);
            M_SQUARE: cnt = CNT_W'(span - SPAN_W'(fold));
            default:  cnt = CNT_W'(span) - wrap_d;
        endcase
    end

endmodule

// File: rtl/ic_channel.sv
// Interval counter channel top. Holds the starting count, expands zero to
// 2^CNT_W, and connects the elapsed tracker, waveform decoder and readout.
// Assumes a load may arrive on any cycle; counting waits for tick_i.
module ic_channel
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              gate_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic [2:0]        mode_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              out_o
);

    localparam int SPAN_W = CNT_W + 1;
    localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(1) << CNT_W;

    ic_mode_e          mode;
    logic [CNT_W-1:0]  init_q;
    logic [SPAN_W-1:0] span;
    logic [CNT_W-1:0]  wrap_d;
    logic [SPAN_W-1:0] run_d;
    logic [SPAN_W-1:0] phase;

    assign mode = fold_mode(mode_i);
    assign span = (init_q == '0) ? FULL_SPAN : {1'b0, init_q};

    // Capture the starting count on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_q <= '0;
        else if (load_i)
            init_q <= load_val_i;
    end

    ic_elapsed #(.CNT_W(CNT_W)) elapsed_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .gate   (gate_i),
        .load   (load_i),
        .mode   (mode),
        .span   (span),
        .wrap_d (wrap_d),
        .run_d  (run_d),
        .phase  (phase)
    );

    ic_wave #(.CNT_W(CNT_W)) wave_i (
        .mode  (mode),
        .span  (span),
        .run_d (run_d),
        .phase (phase),
        .pin   (out_o)
    );

    ic_readout #(.CNT_W(CNT_W)) readout_i (
        .mode   (mode),
        .span   (span),
        .wrap_d (wrap_d),
        .phase  (phase),
        .cnt    (cnt_o)
    );

endmodule

// File: rtl/ic_channel_chk.sv
// Checker for ic_channel: temporal properties on ports and the held count.
// Assumes it is bound into every ic_channel instance.
module ic_channel_chk #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] cnt_o,
    input  logic             out_o,
    input  logic [CNT_W-1:0] init_q
);

    logic armed = 1'b0;

    // Enable $past-based checks only after one full cycle out of reset.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    // R2: a load shows the loaded value as the count one cycle later.
    a_r2_load_shows_value: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        load_i |=> (cnt_o == $past(load_val_i)));

    // R11: without tick or load, and with the mode held, nothing moves.
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(!tick_i && !load_i) && $stable(mode_i)) |-> ($stable(cnt_o) && $stable(out_o)));

    // R4: once high in mode 0, the pin stays high until a load.
    a_r4_term_sticks: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(out_o && !load_i && mode_i == 3'd0) && mode_i == 3'd0) |-> out_o);

    // R6: a low pulse in mode 2 ends on the next tick when the count exceeds 1.
    a_r6_single_low: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(!out_o && tick_i && !load_i && mode_i == 3'd2 && init_q != CNT_W'(1))
         && $stable(mode_i)) |-> out_o);

    // R8: a strobe lasts one counting tick.
    a_r8_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(out_o && tick_i && gate_i && !load_i && (mode_i == 3'd4 || mode_i == 3'd5))
         && $stable(mode_i)) |-> !out_o);

endmodule

bind ic_channel ic_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .mode_i     (mode_i),
    .cnt_o      (cnt_o),
    .out_o      (out_o),
    .init_q     (init_q)
);

// File: tb/ic_channel_tb_top.sv
// Bench for ic_channel: directed corners plus seeded random segments, each
// cycle compared against an elapsed-tick model computed here.
module ic_channel_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             gate_i = 1'b0;
    logic             load_i = 1'b0;
    logic [CNT_W-1:0] load_val_i = '0;
    logic [2:0]       mode_i = 3'd3;
    logic [CNT_W-1:0] cnt_o;
    logic             out_o;

    int n_chk  = 0;
    int n_fail = 0;

    // Model state: elapsed ticks, span, gate at last tick.
    int unsigned md  = 0;
    int unsigned mn  = 65536;
    bit          mgq = 1'b0;

    always #5 clk = ~clk;

    ic_channel #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .gate_i     (gate_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .mode_i     (mode_i),
        .cnt_o      (cnt_o),
        .out_o      (out_o)
    );

    function automatic int fold(input int m);
        return (m >= 6) ? m - 4 : m;
    endfunction

    function automatic bit exp_out(input int m, input int unsigned d, input int unsigned n);
        case (fold(m))
            0, 1:    return d >= n;
            2:       return !((d % n) == 0 && d != 0);
            3:       return (d % n) < (n + 1) / 2;
            default: return d == n;
        endcase
    endfunction

    function automatic int unsigned exp_cnt(input int m, input int unsigned d, input int unsigned n);
        case (fold(m))
            2:       return (n - (d % n)) & 32'hFFFF;
            3:       return (n - ((2 * d) % n)) & 32'hFFFF;
            default: return (n - d) & 32'hFFFF;
        endcase
    endfunction

    function automatic string out_tag(input int m);
        case (fold(m))
            0:       return "R4";
            1:       return "R5";
            2:       return (m == 6) ? "R12" : "R6";
            3:       return (m == 7) ? "R12" : "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (elapsed %0d span %0d)", tag, act, exp, md, mn);
        end
    endtask

    // Drive one cycle, advance the model at the edge, compare at the next negedge.
    task automatic step(input bit ld, input int unsigned val, input bit tk, input bit gt,
                        input int m, input string tag_o, input string tag_c);
        load_i = ld; load_val_i = CNT_W'(val); tick_i = tk; gate_i = gt; mode_i = 3'(m);
        @(posedge clk);
        if (ld) begin
            md = 0;
            mn = (val == 0) ? 65536 : val;
        end else if (tk) begin
            if (gt && !mgq && fold(m) inside {1, 2, 3, 5})
                md = 0;
            else if (!(fold(m) inside {0, 4} && !gt))
                md++;
        end
        if (tk) mgq = gt;
        @(negedge clk);
        check(tag_o, out_o, exp_out(m, md, mn));
        check(tag_c, cnt_o, exp_cnt(m, md, mn));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit g;
        void'($urandom(32'h1C0FFEE5));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state in mode 3 with no ticks.
        check("R1", cnt_o, 0);
        check("R1", out_o, 1);

        // R2: reload mid-period restarts and shows the new value.
        step(1, 10, 0, 1, 3, "R2", "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 3, "R7", "R9");
        step(1, 6, 1, 1, 3, "R2", "R2");
        check("R2", cnt_o, 6);

        // R11: no ticks while the gate toggles: state frozen.
        step(1, 7, 0, 0, 2, "R11", "R11");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 2, "R6", "R9");
        for (int i = 0; i < 8; i++) step(0, 0, 0, i[0], 2, "R11", "R11");
        check("R11", cnt_o, 4);

        // R5: one-shot, then a rising gate edge on a tick retriggers it.
        step(1, 3, 0, 0, 1, "R5", "R9");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, "R5", "R9");
        check("R5", out_o, 1);
        step(0, 0, 1, 1, 1, "R5", "R5");
        check("R5", out_o, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, "R5", "R9");

        // R10: a low gate holds modes 0 and 4.
        step(1, 5, 0, 0, 4, "R10", "R10");
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 4, "R10", "R10");
        check("R10", cnt_o, 5);
        for (int i = 0; i < 7; i++) step(0, 0, 1, 1, 4, "R8", "R9");
        step(1, 4, 0, 0, 0, "R10", "R10");
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, "R10", "R10");
        check("R10", out_o, 0);

        // R12: code 6 as rate generator, code 7 as square wave.
        step(1, 4, 0, 1, 6, "R12", "R12");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 1, 6, "R12", "R12");
        step(1, 5, 0, 1, 7, "R12", "R12");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 1, 7, "R12", "R12");

        // R3: zero loads as 65536; run mode 0 past the terminal point.
        step(1, 0, 0, 1, 0, "R3", "R3");
        check("R3", cnt_o, 0);
        for (int i = 0; i < 65540; i++) step(0, 0, 1, 1, 0, "R3", "R3");
        check("R3", out_o, 1);

        // Random segments over all mode codes, small counts, sparse ticks.
        g = 1'b1;
        for (int s = 0; s < 60; s++) begin
            int m;
            int unsigned n;
            m = int'($urandom % 8);
            n = 1 + ($urandom % 24);
            step(1, n, ($urandom % 2) == 0, g, m, "R2", "R2");
            for (int i = 0; i < 50; i++) begin
                if (($urandom % 8) == 0) g = !g;
                step(0, 0, ($urandom % 4) != 0, g, m, out_tag(m), "R9");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule